// File: doc/BRIEF.md
# Pseudo-Carry Binary Adder

A purely combinational two's-complement adder of parameterised width. It takes two operands and a carry-in and returns the sum, the unsigned carry-out and a signed overflow flag. Internally it does not run the usual generate/propagate carry chain. Each bit forms three terms from its operand bits: a generate (AND), a transmit (OR) and a propagate (XOR). A pseudo-carry recurrence built from generate and transmit reaches back four bit positions per step, so the dependency chain is one quarter of the width.

The pseudo-carry works because a bit that generates also transmits. The true carry into a bit is the pseudo-carry at that bit ANDed with the transmit term of the bit below. The carry-in is treated as a generate at a virtual position below bit 0, and that position always transmits. Propagate is used only in the final sum XOR.

The width must be a positive multiple of four. Any other value stops elaboration.

Top module: `ling_adder`

## Requirements
- R1: `sum` equals the low W bits of the unsigned value a + b + cin.
- R2: `cout` equals bit W of the unsigned value a + b + cin.
- R3: `ovf` is 1 exactly when the signed two's-complement value a + b + cin lies outside the range -2^(W-1) to 2^(W-1)-1.
- R4: With a all ones, b zero and cin 1, the carry passes through every bit position: `sum` is all zeros and `cout` is 1. With cin 0 the same operands give `sum` all ones and `cout` 0.
- R5: With both operands zero, `sum` equals cin in bit 0 and zero elsewhere, and `cout` and `ovf` are both 0.
- R6: The adder gives the R1 to R3 results at any width that is a multiple of four. At a width of 8 this holds for every operand pair with either carry-in.
- R7: The outputs depend only on the present inputs. A new operand pair gives its result within the same cycle, with no state carried over from earlier inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand |
| b | input | W | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | W | Sum bits |
| cout | output | 1 | Carry out of the top bit |
| ovf | output | 1 | Signed overflow |

## Verification
The block holds no state, so a wrong pseudo-carry term shows up at the ports in the same cycle as the operands that reach it. It appears as a wrong sum bit at the first position where that carry is used. It can also appear in `cout` and `ovf` when the fault lies in the top group. A fault in the four-bit look-back term shows only when a carry has to cross a group boundary. For that reason the exhaustive 8-bit sweep and the all-ones carry run matter more than random data. Random data rarely makes a carry cross more than a few bits.

// File: rtl/ling_adder.sv
module ling_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  localparam int OFS = 5;
  localparam int XW  = W + OFS;

  if (W < 4 || (W % 4) != 0) begin : g_width_bad
    $error("ling_adder: W must be a positive multiple of 4");
  end

  logic [W-1:0]  p;
  logic [XW-1:0] gx;
  logic [XW-1:0] tx;
  logic [W:0]    c;

  assign p  = a ^ b;
  assign gx = {a & b, cin, 4'b0000};
  assign tx = {a | b, 1'b1, 4'b0000};

  for (genvar i = 0; i <= W; i++) begin : g_bit
    logic h;
    logic hback;
    if (i >= 4) begin : g_back
      assign hback = g_bit[i-4].h;
    end else begin : g_noback
      assign hback = 1'b0;
    end
    assign h = gx[i+OFS-1]
             | gx[i+OFS-2]
             | (tx[i+OFS-2] & gx[i+OFS-3])
             | (tx[i+OFS-2] & tx[i+OFS-3] & gx[i+OFS-4])
             | (tx[i+OFS-2] & tx[i+OFS-3] & tx[i+OFS-4] & tx[i+OFS-5] & hback);
    assign c[i] = tx[i+OFS-1] & h;
  end

  assign sum  = p ^ c[W-1:0];
  assign cout = c[W];
  assign ovf  = c[W] ^ c[W-1];
endmodule

module ling_adder_chk #(
  parameter int W = 16
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         cin,
  input logic [W-1:0] sum,
  input logic         cout,
  input logic         ovf
);
  logic [W:0] wide;
  assign wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};

  always_comb begin
    a_r1_sum_bits: assert (sum == wide[W-1:0]);
    a_r2_carry_out: assert (cout == wide[W]);
    a_r3_signed_ovf: assert (ovf == ((a[W-1] == b[W-1]) && (sum[W-1] != a[W-1])));
    if (a == '0 && b == '0) begin
      a_r5_zero_in: assert (sum == {{(W-1){1'b0}}, cin} && !cout && !ovf);
    end
    if (a == '1 && b == '0 && cin) begin
      a_r4_full_ripple: assert (sum == '0 && cout);
    end
  end
endmodule

bind ling_adder ling_adder_chk #(.W(W)) u_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout), .ovf(ovf)
);

// File: tb/tb_ling_adder.sv
module tb_ling_adder;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 16;
  localparam int WS = 8;
  localparam int NRAND = 20000;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W-1:0]  a = '0, b = '0;
  logic          cin = 1'b0;
  logic [W-1:0]  sum;
  logic          cout, ovf;

  logic [WS-1:0] sa = '0, sb = '0;
  logic [WS-1:0] s0, s1;
  logic          co0, co1, ov0, ov1;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  ling_adder #(.W(W)) dut (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout), .ovf(ovf));
  ling_adder #(.W(WS)) dut8_c0 (.a(sa), .b(sb), .cin(1'b0), .sum(s0), .cout(co0), .ovf(ov0));
  ling_adder #(.W(WS)) dut8_c1 (.a(sa), .b(sb), .cin(1'b1), .sum(s1), .cout(co1), .ovf(ov1));

  task automatic chk(input string req, input longint got, input longint exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got=%0h expected=%0h (a=%0h b=%0h cin=%0d sa=%0h sb=%0h)",
               req, got, exp, a, b, cin, sa, sb);
    end
  endtask

  task automatic model(input int w, input longint x, input longint y, input int ci,
                       output longint es, output longint ec, output longint eo);
    longint full, sx, sy, ss, lo, hi;
    full = x + y + ci;
    es = full & ((64'sd1 <<< w) - 1);
    ec = (full >>> w) & 1;
    sx = (x >= (64'sd1 <<< (w-1))) ? x - (64'sd1 <<< w) : x;
    sy = (y >= (64'sd1 <<< (w-1))) ? y - (64'sd1 <<< w) : y;
    ss = sx + sy + ci;
    lo = -(64'sd1 <<< (w-1));
    hi = (64'sd1 <<< (w-1)) - 1;
    eo = (ss < lo || ss > hi) ? 1 : 0;
  endtask

  task automatic check16(input string tag);
    longint es, ec, eo;
    model(W, longint'(a), longint'(b), int'(cin), es, ec, eo);
    chk({tag, " R1 sum"}, longint'(sum), es);
    chk({tag, " R2 cout"}, longint'(cout), ec);
    chk({tag, " R3 ovf"}, longint'(ovf), eo);
  endtask

  task automatic apply16(input logic [W-1:0] x, input logic [W-1:0] y, input logic ci, input string tag);
    @(posedge clk);
    a = x; b = y; cin = ci;
    @(negedge clk);
    check16(tag);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got=%0d expected<=%0d cycles", cyc, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R5 reset sum", longint'(sum), 0);
    chk("R5 reset cout", longint'(cout), 0);
    chk("R5 reset ovf", longint'(ovf), 0);
    rst = 1'b0;

    apply16('0, '0, 1'b1, "R5 zero cin1");
    chk("R5 zero cin1 sum", longint'(sum), 1);
    apply16('1, '0, 1'b1, "R4 ripple cin1");
    chk("R4 ripple sum", longint'(sum), 0);
    chk("R4 ripple cout", longint'(cout), 1);
    apply16('1, '0, 1'b0, "R4 ripple cin0");
    chk("R4 no ripple sum", longint'(sum), 64'hFFFF);
    chk("R4 no ripple cout", longint'(cout), 0);
    apply16(16'h7FFF, 16'h0000, 1'b1, "R3 max plus one");
    apply16(16'h8000, 16'h8000, 1'b0, "R3 min plus min");
    apply16(16'h8000, 16'hFFFF, 1'b0, "R3 min minus one");
    apply16(16'h0FFF, 16'h0001, 1'b0, "R1 group cross");
    apply16(16'h5555, 16'hAAAA, 1'b1, "R1 alt bits");

    for (int k = 0; k < NRAND; k++) begin
      apply16(W'($urandom), W'($urandom), 1'($urandom), "R7 random");
    end

    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        longint es, ec, eo;
        @(posedge clk);
        sa = WS'(x); sb = WS'(y);
        @(negedge clk);
        model(WS, longint'(x), longint'(y), 0, es, ec, eo);
        chk("R6 w8 cin0 sum", longint'(s0), es);
        chk("R6 w8 cin0 cout", longint'(co0), ec);
        chk("R6 w8 cin0 ovf", longint'(ov0), eo);
        model(WS, longint'(x), longint'(y), 1, es, ec, eo);
        chk("R6 w8 cin1 sum", longint'(s1), es);
        chk("R6 w8 cin1 cout", longint'(co1), ec);
        chk("R6 w8 cin1 ovf", longint'(ov1), eo);
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule